// File: doc/BRIEF.md
# Sector Hit-Pattern Mask Trigger

This block makes the first-level trigger decision for one azimuthal sector of a silicon-ring tracking trigger. The discriminated pad signals of the sector arrive asynchronously. Each group of pads that belongs to one ring is ORed into a single ring bit. The ring bits are latched on the common machine clock into a hit pattern, one bit per ring. That pattern is compared in parallel against a bank of run-time loadable track masks. An optional multiplicity cut can qualify the result. The block yields one trigger bit per clock with a fixed latency and never stalls.

Every mask slot has its own enable bit and its own chaining input. A second group of planes can therefore require a linked track: it feeds the per-slot local match of this group, which is brought out on a matching output bus, into its own chaining inputs. The synchronized pattern is also shifted into a delay line. A selectable tap presents the pattern from a chosen number of clocks earlier, for a later trigger level. Masks and the control fields are written through a simple address, data and write-strobe port.

Top module: `sector_track_trigger`

## Requirements
- R1: Ring bit r of the hit pattern is the OR of pad inputs 4r to 4r+3 (default four pads per ring, 32 rings).
- R2: While reset is asserted and directly after it, trigOut, extOut and pipeOut are all zero and every mask slot is disabled.
- R3: trigOut is updated on every clock with no stall. The value seen after clock edge N comes from the pads sampled at edge N-2 and the chaining inputs sampled at edge N-1.
- R4: Slot i matches when it is enabled and every bit set in its mask is also set in the latched pattern, i.e. (pattern AND mask) == mask. An enabled all-zero mask therefore matches any pattern, including an empty one.
- R5: A write with cfgAddr bit 6 = 0 loads cfgData into the mask of slot cfgAddr[5:0] and sets that slot's enable to cfgSlotOn. It takes effect from the next clock. A disabled slot never matches.
- R6: A matching slot contributes to the trigger only if its extIn bit is high. With all extIn bits of matching slots low, trigOut stays 0.
- R7: extOut[i] is the local match of slot i (enable and mask rule, not gated by extIn) for the currently latched pattern. It is valid in the clock after the pads are sampled.
- R8: A write with cfgAddr bit 6 = 1 sets the cut enable from cfgData[0] and the 6-bit threshold from cfgData[6:1]. With the cut on, trigOut also needs the count of set ring bits to be at least the threshold. With the cut off, the count has no effect.
- R9: The same control write sets the tap from cfgData[11:7]. After edge N, pipeOut equals the ring pattern of the pads sampled at edge N-1-tap (delay line depth 32).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common machine clock |
| rstN | input | 1 | Asynchronous active-low reset |
| padHits | input | 128 | Discriminated pad signals, four per ring |
| extIn | input | 64 | Per-slot chaining inputs; tie high when unused |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 7 | Bit 6 selects control (1) or mask slot (0); bits 5:0 pick the slot |
| cfgData | input | 32 | Mask value, or control fields (cut, threshold, tap) |
| cfgSlotOn | input | 1 | Enable written together with a mask |
| trigOut | output | 1 | Sector trigger decision |
| extOut | output | 64 | Per-slot local match for chaining |
| pipeOut | output | 32 | Delayed hit pattern at the selected tap |

## Verification
The embedded properties check several relations on every clock. A raised trigger must trace back to a slot that both matched and had its chaining input high. With the cut on, a raised trigger must come from a pattern whose count met the threshold. A slot written as disabled must stop matching. The head of the delay line must follow the latched pattern. A control write must land in the threshold register. The exact pad-to-ring mapping, the two-clock latency, the mask containment rule across many random patterns and masks, the deep tap delays, and the threshold boundary where the count equals the threshold all need bench scenarios. There, a bench model predicts every output cycle by cycle.

// File: rtl/sector_trig_pkg.sv
package sector_trig_pkg;

  // Strobes decoded by the control block for the datapath.
  typedef struct packed {
    logic maskWr;   // load a mask slot this cycle
    logic slotOn;   // enable value stored with the mask
    logic ctlWr;    // load the control fields this cycle
  } cfgStrobe_t;

endpackage

// File: rtl/sector_trig_ctrl.sv
module sector_trig_ctrl
  import sector_trig_pkg::*;
#(
  parameter  int NUM_RINGS  = 32,
  parameter  int PIPE_DEPTH = 32,
  localparam int CNT_W      = $clog2(NUM_RINGS + 1),
  localparam int TAP_W      = (PIPE_DEPTH > 1) ? $clog2(PIPE_DEPTH) : 1,
  localparam int CTL_W      = 1 + CNT_W + TAP_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic             isCtl,
  input  logic             cfgSlotOn,
  input  logic [CTL_W-1:0] ctlData,
  output cfgStrobe_t       strobe,
  output logic             cutOn,
  output logic [CNT_W-1:0] thr,
  output logic [TAP_W-1:0] tapSel
);

  always_comb begin
    strobe.maskWr = cfgWrEn && !isCtl;
    strobe.ctlWr  = cfgWrEn && isCtl;
    strobe.slotOn = cfgSlotOn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cutOn  <= 1'b0;
      thr    <= '0;
      tapSel <= '0;
    end else if (strobe.ctlWr) begin
      cutOn  <= ctlData[0];
      thr    <= ctlData[CNT_W:1];
      tapSel <= ctlData[CTL_W-1:CNT_W+1];
    end
  end

  AST_CTL_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && isCtl) |=> (thr == $past(ctlData[CNT_W:1]))); // R8

endmodule

// File: rtl/sector_trig_dp.sv
module sector_trig_dp
  import sector_trig_pkg::*;
#(
  parameter  int NUM_RINGS     = 32,
  parameter  int PADS_PER_RING = 4,
  parameter  int NUM_MASKS     = 64,
  parameter  int PIPE_DEPTH    = 32,
  parameter  bit PIPE_EN       = 1'b1,
  localparam int SLOT_W        = $clog2(NUM_MASKS),
  localparam int CNT_W         = $clog2(NUM_RINGS + 1),
  localparam int TAP_W         = (PIPE_DEPTH > 1) ? $clog2(PIPE_DEPTH) : 1,
  localparam int PAD_W         = NUM_RINGS * PADS_PER_RING
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [PAD_W-1:0]     padHits,
  input  logic [NUM_MASKS-1:0] extIn,
  input  cfgStrobe_t           strobe,
  input  logic [SLOT_W-1:0]    slot,
  input  logic [NUM_RINGS-1:0] maskData,
  input  logic                 cutOn,
  input  logic [CNT_W-1:0]     thr,
  input  logic [TAP_W-1:0]     tapSel,
  output logic                 trigOut,
  output logic [NUM_MASKS-1:0] extOut,
  output logic [NUM_RINGS-1:0] pipeOut
);

  logic [NUM_RINGS-1:0] ringD;
  logic [NUM_RINGS-1:0] ringQ;
  logic [NUM_RINGS-1:0] maskQ [NUM_MASKS];
  logic [NUM_MASKS-1:0] maskEnQ;
  logic [NUM_MASKS-1:0] localHit;
  logic [NUM_MASKS-1:0] hitQ;
  logic [CNT_W-1:0]     popCnt;
  logic                 multOkQ;
  logic                 trigQ;

  // Stage 1: combine pads per ring, latch on the machine clock.
  for (genvar r = 0; r < NUM_RINGS; r++) begin : g_ring
    assign ringD[r] = |padHits[r*PADS_PER_RING +: PADS_PER_RING];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ringQ <= '0;
    else       ringQ <= ringD;
  end

  // Mask bank.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_MASKS; i++) maskQ[i] <= '0;
      maskEnQ <= '0;
    end else if (strobe.maskWr) begin
      maskQ[slot]   <= maskData;
      maskEnQ[slot] <= strobe.slotOn;
    end
  end

  for (genvar i = 0; i < NUM_MASKS; i++) begin : g_match
    assign localHit[i] = maskEnQ[i] && ((ringQ & maskQ[i]) == maskQ[i]);
  end

  assign extOut = localHit;
  assign popCnt = CNT_W'($countones(ringQ));

  // Stage 2: chaining gate and multiplicity cut. Stage 3: decision.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hitQ    <= '0;
      multOkQ <= 1'b0;
      trigQ   <= 1'b0;
    end else begin
      hitQ    <= localHit & extIn;
      multOkQ <= !cutOn || (popCnt >= thr);
      trigQ   <= (|hitQ) && multOkQ;
    end
  end

  assign trigOut = trigQ;

  // Delay line for the later trigger level.
  if (PIPE_EN) begin : g_pipe
    logic [NUM_RINGS-1:0] pipeQ [PIPE_DEPTH];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int k = 0; k < PIPE_DEPTH; k++) pipeQ[k] <= '0;
      end else begin
        pipeQ[0] <= ringQ;
        for (int k = 1; k < PIPE_DEPTH; k++) pipeQ[k] <= pipeQ[k-1];
      end
    end
    assign pipeOut = (int'(tapSel) < PIPE_DEPTH) ? pipeQ[tapSel] : '0;

    AST_PIPE_HEAD: assert property (@(posedge clk) disable iff (!rstN)
      (tapSel == '0) |-> (pipeOut == $past(ringQ))); // R9
  end else begin : g_nopipe
    assign pipeOut = '0;
  end

  AST_TRIG_NEEDS_TRACK: assert property (@(posedge clk) disable iff (!rstN)
    trigQ |-> $past(|(localHit & extIn), 2)); // R6

  AST_CUT_HONORED: assert property (@(posedge clk) disable iff (!rstN)
    (trigQ && $past(cutOn, 2)) |-> $past(popCnt >= thr, 2)); // R8

  AST_OFF_SLOT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.maskWr && !strobe.slotOn) |=> !localHit[$past(slot)]); // R5

endmodule

// File: rtl/sector_track_trigger.sv
module sector_track_trigger
  import sector_trig_pkg::*;
#(
  parameter int NUM_RINGS     = 32,
  parameter int PADS_PER_RING = 4,
  parameter int NUM_MASKS     = 64,
  parameter int PIPE_DEPTH    = 32,
  parameter bit PIPE_EN       = 1'b1
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic [NUM_RINGS*PADS_PER_RING-1:0]  padHits,
  input  logic [NUM_MASKS-1:0]                extIn,
  input  logic                                cfgWrEn,
  input  logic [$clog2(NUM_MASKS):0]          cfgAddr,
  input  logic [NUM_RINGS-1:0]                cfgData,
  input  logic                                cfgSlotOn,
  output logic                                trigOut,
  output logic [NUM_MASKS-1:0]                extOut,
  output logic [NUM_RINGS-1:0]                pipeOut
);

  localparam int SLOT_W = $clog2(NUM_MASKS);
  localparam int CNT_W  = $clog2(NUM_RINGS + 1);
  localparam int TAP_W  = (PIPE_DEPTH > 1) ? $clog2(PIPE_DEPTH) : 1;
  localparam int CTL_W  = 1 + CNT_W + TAP_W;

  cfgStrobe_t       strobe;
  logic             cutOn;
  logic [CNT_W-1:0] thr;
  logic [TAP_W-1:0] tapSel;

  sector_trig_ctrl #(
    .NUM_RINGS (NUM_RINGS),
    .PIPE_DEPTH(PIPE_DEPTH)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWrEn  (cfgWrEn),
    .isCtl    (cfgAddr[SLOT_W]),
    .cfgSlotOn(cfgSlotOn),
    .ctlData  (cfgData[CTL_W-1:0]),
    .strobe   (strobe),
    .cutOn    (cutOn),
    .thr      (thr),
    .tapSel   (tapSel)
  );

  sector_trig_dp #(
    .NUM_RINGS    (NUM_RINGS),
    .PADS_PER_RING(PADS_PER_RING),
    .NUM_MASKS    (NUM_MASKS),
    .PIPE_DEPTH   (PIPE_DEPTH),
    .PIPE_EN      (PIPE_EN)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .padHits (padHits),
    .extIn   (extIn),
    .strobe  (strobe),
    .slot    (cfgAddr[SLOT_W-1:0]),
    .maskData(cfgData),
    .cutOn   (cutOn),
    .thr     (thr),
    .tapSel  (tapSel),
    .trigOut (trigOut),
    .extOut  (extOut),
    .pipeOut (pipeOut)
  );

endmodule

// File: tb/sector_track_trigger_bench.sv
module sector_track_trigger_bench;
  localparam int NR = 32;
  localparam int NP = 4;
  localparam int NM = 64;
  localparam int HN = 4096;

  logic            clk = 1'b0;
  logic            rstN;
  logic [NR*NP-1:0] padHits;
  logic [NM-1:0]   extIn;
  logic            cfgWrEn;
  logic [6:0]      cfgAddr;
  logic [NR-1:0]   cfgData;
  logic            cfgSlotOn;
  logic            trigOut;
  logic [NM-1:0]   extOut;
  logic [NR-1:0]   pipeOut;

  always #4 clk = ~clk;  // 125 MHz

  sector_track_trigger u_sector_track_trigger (
    .clk(clk), .rstN(rstN), .padHits(padHits), .extIn(extIn),
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .cfgSlotOn(cfgSlotOn), .trigOut(trigOut), .extOut(extOut),
    .pipeOut(pipeOut)
  );

  int errs = 0;
  int checks = 0;
  int n = 0;
  int settle = 0;
  bit finished = 0;
  string phase = "R2 reset";

  logic [NR-1:0] mMask [NM];
  bit            mEn   [NM];
  bit            mCut  = 0;
  int            mThr  = 0;
  int            mTap  = 0;
  logic [NR-1:0] ringHist [HN];
  logic [NM-1:0] extHist  [HN];

  function automatic logic [NR-1:0] ringOf(logic [NR*NP-1:0] p);
    logic [NR-1:0] r = '0;
    for (int i = 0; i < NR; i++) r[i] = |p[i*NP +: NP];
    return r;
  endfunction

  function automatic logic [NM-1:0] localOf(logic [NR-1:0] ring);
    logic [NM-1:0] h = '0;
    for (int i = 0; i < NM; i++) h[i] = mEn[i] && ((ring & mMask[i]) == mMask[i]);
    return h;
  endfunction

  function automatic logic trigOf(logic [NR-1:0] ring, logic [NM-1:0] ext);
    return (|(localOf(ring) & ext)) && (!mCut || ($countones(ring) >= mThr));
  endfunction

  function automatic logic [NR-1:0] ringAt(int i);
    return (i < 0) ? '0 : ringHist[i % HN];
  endfunction

  function automatic logic [NM-1:0] extAt(int i);
    return (i < 0) ? '1 : extHist[i % HN];
  endfunction

  task automatic check(string req, logic [NM-1:0] act, logic [NM-1:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s [%s] actual=%h expected=%h", req, phase, act, exp);
    end
  endtask

  // At a falling edge: check outputs against the model, then drive new inputs.
  task automatic step(logic [NR*NP-1:0] pads, logic [NM-1:0] ext);
    if (settle > 0) settle--;
    else begin
      check("R3 trigger", NM'(trigOut), NM'(trigOf(ringAt(n-3), extAt(n-2))));
      check("R7 extOut", extOut, localOf(ringAt(n-1)));
      check("R9 pipeOut (R1 ring OR)", NM'(pipeOut), NM'(ringAt(n-2-mTap)));
    end
    ringHist[n % HN] = ringOf(pads);
    extHist[n % HN]  = ext;
    padHits = pads;
    extIn   = ext;
    @(posedge clk);
    @(negedge clk);
    cfgWrEn = 1'b0;
    n++;
  endtask

  task automatic cfgWrite(logic [6:0] addr, logic [NR-1:0] data, logic on);
    cfgWrEn = 1'b1; cfgAddr = addr; cfgData = data; cfgSlotOn = on;
    if (!addr[6]) begin
      mMask[addr[5:0]] = data;
      mEn[addr[5:0]]   = on;
    end else begin
      mCut = data[0];
      mThr = int'(data[6:1]);
      mTap = int'(data[11:7]);
    end
    settle = 5;
    step('0, '1);
  endtask

  function automatic logic [NR*NP-1:0] randPads();
    logic [NR*NP-1:0] p;
    for (int w = 0; w < NP; w++) p[w*32 +: 32] = $urandom & $urandom;
    return p;
  endfunction

  function automatic logic [NM-1:0] randExt();
    return {$urandom | $urandom, $urandom | $urandom};
  endfunction

  function automatic logic [NR*NP-1:0] ringsPads(int count);
    logic [NR*NP-1:0] p = '0;
    for (int r = 0; r < count; r++) p[r*NP + (r % NP)] = 1'b1;
    return p;
  endfunction

  initial begin
    process::self().srandom(32'h5EC7);
    for (int i = 0; i < NM; i++) begin mMask[i] = '0; mEn[i] = 0; end
    for (int i = 0; i < HN; i++) begin ringHist[i] = '0; extHist[i] = '1; end
    rstN = 1'b0; padHits = '0; extIn = '1;
    cfgWrEn = 1'b0; cfgAddr = '0; cfgData = '0; cfgSlotOn = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R2 reset trigOut", NM'(trigOut), '0);
    check("R2 reset extOut", extOut, '0);
    check("R2 reset pipeOut", NM'(pipeOut), '0);
    rstN = 1'b1;
    step('0, '1);
    check("R2 after reset extOut", extOut, '0);

    phase = "R4 random masks";
    for (int s = 8; s < 16; s++) cfgWrite(7'(s), $urandom & $urandom & $urandom, 1'b1);
    for (int c = 0; c < 300; c++) step(randPads(), randExt());

    phase = "R8 R9 cut and deep tap";
    cfgWrite(7'h40, NR'((31 << 7) | (10 << 1) | 1), 1'b0);
    for (int c = 0; c < 300; c++) step(randPads(), randExt());
    cfgWrite(7'h40, NR'((13 << 7) | (7 << 1) | 1), 1'b0);
    for (int c = 0; c < 200; c++) step(randPads(), randExt());

    // Clear the random slots and the cut for the directed corners.
    for (int s = 8; s < 16; s++) cfgWrite(7'(s), '0, 1'b0);
    cfgWrite(7'h40, '0, 1'b0);

    phase = "R4 zero mask matches empty pattern";
    cfgWrite(7'd63, '0, 1'b1);
    for (int c = 0; c < 6; c++) step('0, '1);

    phase = "R6 extIn low blocks slot";
    for (int c = 0; c < 6; c++) step('0, ~(64'd1 << 63));
    phase = "R6 only matching slot ext high";
    for (int c = 0; c < 6; c++) step(randPads(), 64'd1 << 63);

    phase = "R5 disabled slot";
    cfgWrite(7'd63, '0, 1'b0);
    for (int c = 0; c < 6; c++) step(randPads(), '1);

    phase = "R8 cut boundary";
    cfgWrite(7'd0, '0, 1'b1);
    cfgWrite(7'h40, NR'((5 << 1) | 1), 1'b0);
    for (int c = 0; c < 5; c++) step(ringsPads(5), '1);
    for (int c = 0; c < 5; c++) step(ringsPads(4), '1);
    for (int c = 0; c < 5; c++) step(ringsPads(32), '1);
    cfgWrite(7'h40, NR'((32 << 1) | 1), 1'b0);
    for (int c = 0; c < 5; c++) step(ringsPads(32), '1);
    for (int c = 0; c < 5; c++) step(ringsPads(31), '1);
    phase = "R8 cut off ignores count";
    cfgWrite(7'h40, NR'(32 << 1), 1'b0);
    for (int c = 0; c < 6; c++) step(ringsPads(1), '1);

    phase = "R1 single pad per ring";
    cfgWrite(7'h40, NR'(3 << 7), 1'b0);
    for (int c = 0; c < 40; c++) begin
      logic [NR*NP-1:0] p = '0;
      for (int r = 0; r < NR; r++) if ($urandom_range(1, 0) == 1) p[r*NP + $urandom_range(NP-1, 0)] = 1'b1;
      step(p, '1);
    end

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errs++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule